// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block stands between a requester and a register path whose reads sometimes return a wrong value. One start pulse with an address begins a filtered read. The block then reads the addressed register a fixed number of times, `NSAMP` by default 100, through a request/response port. Each side of that port has its own valid/ready handshake, so the block accepts any latency at the far end. Only one sample is in flight at a time.

All samples are stored before any tallying begins. The tally walks the samples in arrival order and keeps a table of distinct values with a count for each. For every sample it scans the table one entry per cycle. A match increments that entry's count. A sample that reaches the end of the table without a match becomes a new entry with count one. A running maximum follows the counts and moves only when a count rises strictly above it. Tallying stops as soon as the maximum passes half the sample count. The value holding the maximum is returned with a one-cycle done pulse.

Top module: `mode_vote_reader`

## Requirements
- R1: While reset is applied and after its release with no start, the sample request valid and done are low and the result is zero.
- R2: A start accepted while idle produces exactly NSAMP sample requests, each carrying the address given with that start. A new request is raised only after the response to the previous one has been accepted.
- R3: A sample request whose ready is low keeps valid high and its address unchanged in the next cycle.
- R4: The result equals the value that occurs most often among the NSAMP samples.
- R5: On equal counts, the result is the value that first reached the tied count in sample order. When all samples are distinct, the result is therefore the first sample.
- R6: Once one value's count exceeds NSAMP/2 (integer division), tallying stops with that value as the result. With all samples equal, done rises no more than NSAMP/2+4 cycles after the last response is accepted.
- R7: Done is high for exactly one cycle per filtered read. The result is updated only with done and holds its value until the next done.
- R8: A start raised while a filtered read is in progress is ignored: the address of the requests does not change and only one done follows.
- R9: A start raised in the same cycle as done is accepted, and the sample request rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a filtered read (taken only when idle) |
| addr_i | input | ADDR_W | Register address for the filtered read |
| smp_req_valid_o | output | 1 | Sample request valid |
| smp_req_ready_i | input | 1 | Sample request accepted |
| smp_addr_o | output | ADDR_W | Address of the sample request |
| smp_rsp_valid_i | input | 1 | Sample response valid |
| smp_rsp_ready_o | output | 1 | Block is ready to take the sample response |
| smp_rsp_data_i | input | DATA_W | Sampled register value |
| done_o | output | 1 | One-cycle pulse: result is valid |
| result_o | output | DATA_W | Filtered (most frequent) value |

## Verification
Two ways of ending the tally can fall on the same step. These are the majority early stop and the completion of the final sample. The bench provokes this with a pattern that fills the first 49 slots with distinct values and the last 51 with one value, so the majority is first reached on sample 100. It then checks that exactly one done pulse appears and that it carries that value. Done and a new start also coincide: the bench raises start in the done cycle and expects the sample request in the next cycle and a correct second result.

// File: rtl/mode_vote_reader.sv
module mode_vote_reader #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int NSAMP  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              smp_req_valid_o,
  input  logic              smp_req_ready_i,
  output logic [ADDR_W-1:0] smp_addr_o,
  input  logic              smp_rsp_valid_i,
  output logic              smp_rsp_ready_o,
  input  logic [DATA_W-1:0] smp_rsp_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int CW = $clog2(NSAMP + 1);
  localparam int HALF = NSAMP / 2;
  localparam logic [CW-1:0] LAST   = CW'(NSAMP - 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] ONE    = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_TALLY} st_t;

  st_t               state;
  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     si, ti, nent, maxc, maxi;
  logic              done_q;
  logic [DATA_W-1:0] res_q;

  logic [DATA_W-1:0] samp [NSAMP];
  logic [DATA_W-1:0] tval [NSAMP];
  logic [CW-1:0]     tcnt [NSAMP];

  logic [DATA_W-1:0] cur;
  logic              scan_end, hit, step, upd, fin;
  logic [CW-1:0]     newc, nmax, nmaxi;

  assign cur      = samp[si];
  assign scan_end = (ti == nent);
  assign hit      = !scan_end && (tval[ti] == cur);
  assign step     = (state == S_TALLY) && (hit || scan_end);
  assign newc     = scan_end ? ONE : tcnt[ti] + ONE;
  assign upd      = step && (newc > maxc);
  assign nmax     = upd ? newc : maxc;
  assign nmaxi    = upd ? ti : maxi;
  assign fin      = step && ((nmax > HALF_C) || (si == LAST));

  assign smp_req_valid_o = (state == S_REQ);
  assign smp_rsp_ready_o = (state == S_WAIT);
  assign smp_addr_o      = addr_q;
  assign done_o          = done_q;
  assign result_o        = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr_q <= '0;
      si     <= '0;
      ti     <= '0;
      nent   <= '0;
      maxc   <= '0;
      maxi   <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          addr_q <= addr_i;
          si     <= '0;
          state  <= S_REQ;
        end
        S_REQ: if (smp_req_ready_i) state <= S_WAIT;
        S_WAIT: if (smp_rsp_valid_i) begin
          if (si == LAST) begin
            si    <= '0;
            ti    <= '0;
            nent  <= '0;
            maxc  <= '0;
            maxi  <= '0;
            state <= S_TALLY;
          end else begin
            si    <= si + ONE;
            state <= S_REQ;
          end
        end
        S_TALLY: begin
          if (step) begin
            si   <= si + ONE;
            ti   <= '0;
            maxc <= nmax;
            maxi <= nmaxi;
            if (scan_end) nent <= nent + ONE;
            if (fin) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
              res_q  <= upd ? cur : tval[maxi];
            end
          end else begin
            ti <= ti + ONE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_WAIT && smp_rsp_valid_i) samp[si] <= smp_rsp_data_i;
    if (step) begin
      if (scan_end) begin
        tval[nent] <= cur;
        tcnt[nent] <= ONE;
      end else begin
        tcnt[ti] <= newc;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    smp_req_valid_o && !smp_req_ready_i |=> smp_req_valid_o && $stable(smp_addr_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R7
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(smp_addr_o)); // R8
  AST_TALLY_NO_MAJ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TALLY) |-> (maxc <= HALF_C)); // R6

endmodule

// File: tb/mode_vote_reader_tb_top.sv
module mode_vote_reader_tb_top;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NS = 100;
  localparam int HALF = NS / 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, start, smp_req_ready, smp_rsp_valid;
  logic [AW-1:0] addr;
  logic [DW-1:0] smp_rsp_data;
  logic          smp_req_valid_o, smp_rsp_ready_o, done_o;
  logic [AW-1:0] smp_addr_o;
  logic [DW-1:0] result_o;

  mode_vote_reader #(.DATA_W(DW), .ADDR_W(AW), .NSAMP(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
    .smp_req_valid_o(smp_req_valid_o), .smp_req_ready_i(smp_req_ready),
    .smp_addr_o(smp_addr_o), .smp_rsp_valid_i(smp_rsp_valid),
    .smp_rsp_ready_o(smp_rsp_ready_o), .smp_rsp_data_i(smp_rsp_data),
    .done_o(done_o), .result_o(result_o));

  int checks = 0, errors = 0;
  longint cyc = 0, last_rsp_cyc = 0;
  int dones = 0, k = 0, req_seen = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] pat [NS];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (done_o) dones <= dones + 1;

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_mode();
    int best_c = 0;
    logic [DW-1:0] best = '0;
    for (int i = 0; i < NS; i++) begin
      int c;
      c = 0;
      for (int j = 0; j <= i; j++) if (pat[j] == pat[i]) c++;
      if (c > best_c) begin best_c = c; best = pat[i]; end
      if (best_c > HALF) break;
    end
    return best;
  endfunction

  initial begin
    smp_req_ready = 1'b0; smp_rsp_valid = 1'b0; smp_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && smp_req_valid_o) begin
        chk(smp_addr_o == exp_addr, "R2 request address", DW'(smp_addr_o), DW'(exp_addr));
        repeat ($urandom_range(0, 2)) @(negedge clk);
        smp_req_ready = 1'b1;
        @(negedge clk);
        smp_req_ready = 1'b0;
        req_seen++;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        smp_rsp_valid = 1'b1;
        smp_rsp_data = (k < NS) ? pat[k] : '0;
        k++;
        last_rsp_cyc = cyc;
        @(negedge clk);
        smp_rsp_valid = 1'b0;
      end
    end
  end

  task automatic launch(logic [AW-1:0] a);
    exp_addr = a; k = 0; req_seen = 0;
    start = 1'b1; addr = a;
    @(negedge clk);
    start = 1'b0; addr = AW'($urandom);
  endtask

  task automatic expect_done(logic [DW-1:0] e, string tag);
    int n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk(done_o, "R7 done arrives", DW'(done_o), 1);
    chk(result_o == e, tag, result_o, e);
    chk(req_seen == NS, "R2 request count", DW'(req_seen), DW'(NS));
  endtask

  task automatic pulse_hold();
    logic [DW-1:0] r;
    r = result_o;
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", DW'(done_o), 0);
    chk(result_o == r, "R7 result held", result_o, r);
  endtask

  task automatic fill_rand();
    logic [DW-1:0] base;
    int nv;
    bit heavy;
    base = $urandom; nv = $urandom_range(2, 6); heavy = 1'($urandom);
    for (int i = 0; i < NS; i++)
      if (heavy && $urandom_range(0, 9) < 6) pat[i] = base;
      else pat[i] = base + DW'($urandom_range(0, nv - 1));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] e;
    int d0;
    longint lat;
    void'($urandom(32'd7));
    rst_n = 1'b0; start = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    chk(!smp_req_valid_o && !done_o, "R1 idle in reset", DW'({smp_req_valid_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!smp_req_valid_o && !done_o, "R1 idle after reset", DW'({smp_req_valid_o, done_o}), 0);
    chk(result_o == '0, "R1 result zero", result_o, 0);

    // R6: all equal, early stop latency
    for (int i = 0; i < NS; i++) pat[i] = 32'hA5A5_0001;
    launch(8'h11);
    expect_done(32'hA5A5_0001, "R6 all equal result");
    lat = cyc - last_rsp_cyc;
    chk(lat <= HALF + 4, "R6 early stop latency", DW'(lat), DW'(HALF + 4));
    pulse_hold();

    // R6 and R4: majority reached on the final sample
    for (int i = 0; i < NS; i++) pat[i] = (i < NS - HALF - 1) ? 32'h100 + DW'(i) : 32'hBEEF;
    d0 = dones;
    launch(8'h22);
    expect_done(exp_mode(), "R6 majority at last sample");
    chk(result_o == 32'hBEEF, "R4 majority value", result_o, 32'hBEEF);
    pulse_hold();
    repeat (5) @(negedge clk);
    chk(dones == d0 + 1, "R7 single done", DW'(dones - d0), 1);

    // R5: first-appearing value loses the tie
    pat[0] = 32'hAAAA;
    for (int i = 1; i < NS; i++) pat[i] = (i <= HALF) ? 32'hBBBB : 32'hAAAA;
    launch(8'h33);
    expect_done(32'hBBBB, "R5 tie to first reaching count");
    pulse_hold();

    // R5: all distinct gives first sample
    for (int i = 0; i < NS; i++) pat[i] = 32'h7000 + DW'(i * 3);
    launch(8'h44);
    expect_done(32'h7000, "R5 all distinct first sample");

    // R9: start in the done cycle
    for (int i = 0; i < NS; i++) pat[i] = (i % 3 == 0) ? 32'h5 : 32'h6;
    e = exp_mode();
    launch(8'h55);
    chk(!done_o, "R7 done one cycle", DW'(done_o), 0);
    chk(smp_req_valid_o, "R9 request after start in done cycle", DW'(smp_req_valid_o), 1);
    expect_done(e, "R9 chained read result");
    pulse_hold();

    // R8: start during a read is ignored
    fill_rand();
    e = exp_mode();
    d0 = dones;
    launch(8'h66);
    repeat (40) @(negedge clk);
    start = 1'b1; addr = 8'h99;
    @(negedge clk);
    start = 1'b0;
    expect_done(e, "R8 result with ignored start");
    repeat (20) @(negedge clk);
    chk(dones == d0 + 1, "R8 one done only", DW'(dones - d0), 1);
    chk(!smp_req_valid_o, "R8 no extra read", DW'(smp_req_valid_o), 0);

    // R4: random patterns
    for (int t = 0; t < 8; t++) begin
      fill_rand();
      e = exp_mode();
      launch(AW'($urandom));
      expect_done(e, "R4 random mode");
      pulse_hold();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule